// File: doc/BRIEF.md
# Serial Register Port with Field Parity

This block is the serial-facing side of a device's configuration space. An external master selects it with an active-low chip select and clocks 24-bit command frames in, most significant bit first. Each command names one of 64 register addresses and asks for either a read or a write. While the command shifts in, the block shifts a 24-bit answer out: a status byte first, then the 16-bit content of the addressed register.

The command carries two even-parity bits, one for the header byte and one for the data half-word. When the parity-check switch in the control register is on, a command that fails either check changes no register and raises a sticky error flag. The switch is off after reset. A chip-select window that holds any count of clocks other than 24 is dropped and raises a separate sticky flag. Both flags are reported in the status byte of the next frame and are cleared by the next frame of correct length.

The serial pins are synchronized into the system clock, which must run at least eight times faster than the serial clock. Register storage is a simple dual-port memory that block RAM can hold. The control register is the exception and sits in flops so that its reset value is defined.

Top module: `spi_parity_regs`

## Requirements
- R1: A 24-bit frame with bit 16 at 0 (write) stores frame bits 14..0 into the register whose address is frame bits 22..17. A later read of that register returns the value with bit 15 as 0.
- R2: A 24-bit frame with bit 16 at 1 (read) returns the register content on MISO bits 15..0 and modifies no register.
- R3: MISO carries 24 bits, most significant first, launched on SCLK rising edges while chip select is low. MOSI is sampled on SCLK falling edges. MISO bits 23..16 are the status byte captured when chip select fell.
- R4: After reset, parity checking is off, and a write frame is committed whatever its parity bits hold.
- R5: Bit 0 of register 63 is the parity-check switch. When it is 1, a write frame is not committed if bits 23..16 or bits 15..0 hold an odd count of ones.
- R6: When checking is on, a write frame whose two fields each hold an even count of ones, parity bit included, is committed.
- R7: If chip select rises after any count of SCLK falling edges other than 24, the frame changes no register and status bit 1 (length error) becomes 1.
- R8: Status bit 0 (parity error) becomes 1 when an enabled check fails on a 24-bit frame, read or write. Frames of other lengths leave it unchanged. A 24-bit frame clears status bits 0 and 1, except that a check failure in that same frame leaves bit 0 at 1.
- R9: On a write frame, MISO bits 15..0 return the register content held before the write.
- R10: MISO is 0 while chip select is high.
- R11: Status bit 2 shows the present state of the parity-check switch. Status bits 7..3 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial command data, master to block |
| miso | output | 1 | Serial answer data, block to master |

## Verification
At the end of a frame, the flag-clearing action and the flag-setting action land in the same cycle. The clear comes from a frame of correct length, and the set comes from that same frame failing its enabled parity check. The bench sends two failing frames back to back, then a third frame, and expects the third frame's status to still show the parity error. It also expects the next good frame to show the flag cleared. The frame boundary likewise combines a write commit with a parity decision. This is exercised by single- and double-field corruption at several addresses, with a read-back afterwards to confirm that the stored value did not change.

// File: rtl/spisl_pkg.sv
package spisl_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_BITS  = 6;
  localparam int HDR_PAR    = FRAME_BITS - 1;
  localparam int ADDR_LSB   = HDR_PAR - ADDR_BITS;
  localparam int RW_POS     = ADDR_LSB - 1;
  localparam int DAT_PAR    = RW_POS - 1;
  localparam int WDATA_BITS = DAT_PAR;
  localparam int RDATA_BITS = WDATA_BITS + 1;
  localparam int STAT_BITS  = FRAME_BITS - RDATA_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [STAT_BITS-4:0] spare;
    logic                 chk_on;
    logic                 len_err;
    logic                 par_err;
  } status_t;
endpackage

// File: rtl/spisl_sync.sv
module spisl_sync #(
  parameter int                WIDTH  = 3,
  parameter int                STAGES = 2,
  parameter logic [WIDTH-1:0]  INIT   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= INIT;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spisl_shifter.sv
module spisl_shifter
  import spisl_pkg::*;
#(
  parameter int FBITS = FRAME_BITS,
  parameter int ABITS = ADDR_BITS,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             mosi_s,
  input  logic [FBITS-1:0] tx_word,
  output logic             cs_start,
  output logic             frame_end,
  output logic             frame_len_ok,
  output logic [FBITS-1:0] frame_word,
  output logic             addr_valid,
  output logic [ABITS-1:0] addr,
  output logic             miso
);
  localparam logic [CW-1:0] FULL_CNT  = CW'(FBITS);
  localparam logic [CW-1:0] ADDR_HIT  = CW'(ABITS);
  localparam logic [CW-1:0] FIRST_POS = CW'(FBITS - 1);

  logic          sclk_d, cs_d;
  logic          rise, fall, cs_stop;
  logic [CW-1:0] rx_cnt;
  logic [CW-1:0] tx_pos;
  logic          tx_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  assign rise     = sclk_s & ~sclk_d & ~cs_n_s;
  assign fall     = ~sclk_s & sclk_d & ~cs_n_s;
  assign cs_start = cs_d & ~cs_n_s;
  assign cs_stop  = ~cs_d & cs_n_s;

  // receive side: count and shift on falling edges
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt       <= '0;
      frame_word   <= '0;
      addr_valid   <= 1'b0;
      frame_end    <= 1'b0;
      frame_len_ok <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      frame_end  <= 1'b0;
      if (cs_start) rx_cnt <= '0;
      if (fall) begin
        frame_word <= {frame_word[FBITS-2:0], mosi_s};
        if (rx_cnt != '1) rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == ADDR_HIT) addr_valid <= 1'b1;
      end
      if (cs_stop) begin
        frame_end    <= 1'b1;
        frame_len_ok <= (rx_cnt == FULL_CNT);
      end
    end
  end

  assign addr = frame_word[ABITS-1:0];

  // transmit side: launch one bit per rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pos  <= FIRST_POS;
      tx_live <= 1'b0;
      miso    <= 1'b0;
    end else if (cs_n_s) begin
      miso    <= 1'b0;
      tx_live <= 1'b0;
    end else begin
      if (cs_start) begin
        tx_pos  <= FIRST_POS;
        tx_live <= 1'b1;
      end else if (rise) begin
        miso <= tx_live ? tx_word[tx_pos] : 1'b0;
        if (tx_pos == '0) tx_live <= 1'b0;
        else tx_pos <= tx_pos - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spisl_regbank.sv
module spisl_regbank #(
  parameter int               ABITS     = 6,
  parameter int               DBITS     = 15,
  parameter logic [ABITS-1:0] CTRL_ADDR = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ABITS-1:0] waddr,
  input  logic [DBITS-1:0] wdata,
  input  logic             re,
  input  logic [ABITS-1:0] raddr,
  output logic [DBITS-1:0] rdata,
  output logic [DBITS-1:0] ctrl
);
  localparam int DEPTH = 1 << ABITS;

  logic [DBITS-1:0] mem [DEPTH];
  logic [DBITS-1:0] mem_q;
  logic             sel_ctrl;

  // storage without reset so that block RAM can hold it
  always_ff @(posedge clk) begin
    if (we && waddr != CTRL_ADDR) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      sel_ctrl <= 1'b0;
    end else begin
      if (we && waddr == CTRL_ADDR) ctrl <= wdata;
      if (re) sel_ctrl <= (raddr == CTRL_ADDR);
    end
  end

  assign rdata = sel_ctrl ? ctrl : mem_q;
endmodule

// File: rtl/spi_parity_regs.sv
module spi_parity_regs
  import spisl_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              PEN_BIT     = 0,
  parameter logic [ADDR_BITS-1:0] CTRL_ADDR = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic                  sclk_s, cs_n_s, mosi_s;
  logic                  cs_start, frame_end, frame_len_ok, addr_valid;
  logic [FRAME_BITS-1:0] frame_word, tx_word;
  logic [ADDR_BITS-1:0]  addr;
  logic [WDATA_BITS-1:0] rdata, ctrl;
  logic                  rd_pend;
  logic [RDATA_BITS-1:0] rd_hold;
  status_t               status, snap;
  logic                  perr, ferr, pen;
  logic                  hdr_bad, dat_bad, chk_fail;
  logic                  wr_en;
  logic [ADDR_BITS-1:0]  wr_addr;
  logic [WDATA_BITS-1:0] wr_data;

  spisl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, mosi}), .q({sclk_s, cs_n_s, mosi_s})
  );

  spisl_shifter u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_word(tx_word), .cs_start(cs_start), .frame_end(frame_end),
    .frame_len_ok(frame_len_ok), .frame_word(frame_word),
    .addr_valid(addr_valid), .addr(addr), .miso(miso)
  );

  spisl_regbank #(.ABITS(ADDR_BITS), .DBITS(WDATA_BITS), .CTRL_ADDR(CTRL_ADDR)) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(addr_valid), .raddr(addr), .rdata(rdata), .ctrl(ctrl)
  );

  assign pen = ctrl[PEN_BIT];

  assign status = '{spare: '0, chk_on: pen, len_err: ferr, par_err: perr};

  // answer word: status snapshot, then the addressed content
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_hold <= '0;
      snap    <= '0;
    end else begin
      rd_pend <= addr_valid;
      if (rd_pend) rd_hold <= {1'b0, rdata};
      if (cs_start) snap <= status;
    end
  end

  assign tx_word = {snap, rd_hold};

  // frame decode and parity gate
  assign hdr_bad  = ^frame_word[HDR_PAR:RW_POS];
  assign dat_bad  = ^frame_word[DAT_PAR:0];
  assign chk_fail = pen & (hdr_bad | dat_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      wr_en   <= frame_end & frame_len_ok & ~frame_word[RW_POS] & ~chk_fail;
      wr_addr <= frame_word[HDR_PAR-1:ADDR_LSB];
      wr_data <= frame_word[WDATA_BITS-1:0];
      if (frame_end) begin
        if (frame_len_ok) begin
          perr <= chk_fail;
          ferr <= 1'b0;
        end else begin
          ferr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spisl_chk.sv
module spisl_chk
  import spisl_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  miso,
  input logic                  cs_n_s,
  input logic                  frame_end,
  input logic                  frame_len_ok,
  input logic [FRAME_BITS-1:0] frame_word,
  input logic                  wr_en,
  input logic                  pen,
  input logic                  perr,
  input logic                  ferr
);
  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso);

  assert_write_gate_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(frame_end && frame_len_ok && !frame_word[RW_POS]));

  assert_parity_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(pen)) |->
      $past(!(^frame_word[HDR_PAR:RW_POS]) && !(^frame_word[DAT_PAR:0])));

  assert_len_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr) |-> $past(frame_end && !frame_len_ok));

  assert_perr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (perr && !frame_end) |=> perr);

  assert_switch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pen));
endmodule

bind spi_parity_regs spisl_chk u_chk (
  .clk(clk), .rst(rst), .miso(miso), .cs_n_s(cs_n_s), .frame_end(frame_end),
  .frame_len_ok(frame_len_ok), .frame_word(frame_word), .wr_en(wr_en),
  .pen(pen), .perr(perr), .ferr(ferr)
);

// File: tb/tb_spi_parity_regs.sv
`timescale 1ns/1ps
module tb_spi_parity_regs;
  localparam int HALF = 8;
  localparam int CTRL = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [14:0] mem_m [64];
  bit          known [64];
  logic [14:0] ctrl_m = '0;
  bit          perr_m = 1'b0;
  bit          ferr_m = 1'b0;

  always #2.5 clk = ~clk;

  spi_parity_regs dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      got = {got[22:0], miso};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  // one frame with the reference model alongside
  task automatic frame(input logic [5:0] a, input bit rw, input logic [14:0] d,
                       input bit hbad, input bit dbad, input int nbits,
                       input string tag);
    logic [23:0] w, got;
    logic [7:0]  exp_st;
    bit          fail;
    w[22:17] = a;
    w[16]    = rw;
    w[14:0]  = d;
    w[23]    = (^w[22:16]) ^ hbad;
    w[15]    = (^w[14:0]) ^ dbad;
    exp_st   = {5'b0, ctrl_m[0], ferr_m, perr_m};
    xfer(w, nbits, got);
    if (nbits == 24) begin
      check({tag, " R3/R11 status"}, 32'(got[23:16]), 32'(exp_st));
      if (a == 6'(CTRL))
        check({tag, rw ? " R2 ctrl read" : " R9 ctrl prior"}, 32'(got[15:0]), 32'({1'b0, ctrl_m}));
      else if (known[a])
        check({tag, rw ? " R2 read" : " R9 prior"}, 32'(got[15:0]), 32'({1'b0, mem_m[a]}));
      fail   = ctrl_m[0] && (hbad || dbad);
      perr_m = fail;
      ferr_m = 1'b0;
      if (!rw && !fail) begin
        if (a == 6'(CTRL)) ctrl_m = d;
        else begin
          mem_m[a] = d;
          known[a] = 1'b1;
        end
      end
    end else begin
      ferr_m = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) known[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 idle miso after reset", 32'(miso), 32'd0);

    // R4: checking off, corrupted parity still commits
    for (int a = 0; a < 63; a++)
      frame(6'(a), 1'b0, 15'(a * 997 + 16'h1234), (a % 3) == 0, (a % 5) == 0, 24, "R4 fill");
    // R1/R9: overwrite, previous content comes back
    for (int a = 0; a < 63; a++)
      frame(6'(a), 1'b0, 15'(~(a * 997 + 16'h1234) ^ a), 1'b0, 1'b0, 24, "R1 rewrite");
    // R2: reads, twice at the same address to show no change
    for (int a = 0; a < 63; a += 4) frame(6'(a), 1'b1, 15'h7fff, 1'b0, 1'b0, 24, "R2 sweep");
    frame(6'd9, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R2 again");
    frame(6'd9, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R2 again");
    check("R10 idle miso between frames", 32'(miso), 32'd0);

    // R5/R11: switch on
    frame(6'(CTRL), 1'b0, 15'h0001, 1'b0, 1'b0, 24, "R5 enable");
    frame(6'(CTRL), 1'b1, 15'h0, 1'b0, 1'b0, 24, "R11 ctrl readback");
    for (int k = 0; k < 3; k++) begin
      for (int v = 1; v < 4; v++) begin
        frame(6'(k * 20 + 1), 1'b0, 15'h5a5a, v[0], v[1], 24, "R5 corrupt");
        frame(6'(k * 20 + 1), 1'b1, 15'h0, 1'b0, 1'b0, 24, "R8 flag shown");
      end
    end
    // R8: set and clear in the same frame, set wins
    frame(6'd4, 1'b0, 15'h1111, 1'b1, 1'b0, 24, "R8 bad one");
    frame(6'd4, 1'b0, 15'h2222, 1'b0, 1'b1, 24, "R8 bad two");
    frame(6'd4, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R8 still set");
    frame(6'd4, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R8 cleared");
    frame(6'd7, 1'b1, 15'h0, 1'b1, 1'b0, 24, "R8 read bad parity");
    // R6: good parity commits with checking on
    frame(6'd4, 1'b0, 15'h3c3c, 1'b0, 1'b0, 24, "R6 good write");
    frame(6'd4, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R6 readback");

    // R7: wrong lengths
    frame(6'd12, 1'b0, 15'h0aaa, 1'b0, 1'b0, 23, "R7 short");
    frame(6'd12, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R7 flag shown");
    frame(6'd12, 1'b0, 15'h0bbb, 1'b0, 1'b0, 25, "R7 long");
    frame(6'd12, 1'b0, 15'h0ccc, 1'b0, 1'b0, 0, "R7 empty");
    frame(6'd12, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R7 readback");
    frame(6'd12, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R7 cleared");

    // switch off again, corrupted write commits
    frame(6'(CTRL), 1'b0, 15'h0000, 1'b0, 1'b0, 24, "R5 disable");
    frame(6'd30, 1'b0, 15'h6543, 1'b1, 1'b1, 24, "R4 off again");
    frame(6'd30, 1'b1, 15'h0, 1'b0, 1'b0, 24, "R4 readback");
    check("R10 idle miso at end", 32'(miso), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule